// File: doc/BRIEF.md
# Noise-Aware Clock Gating Controller

This controller sits between a free-running clock and a processor core that shares a board with a switching power converter. It produces a registered clock enable for the core. Whenever the converter's controller announces a switching event, the controller drops that enable for a window long enough to outlast the switching noise. While the enable is low, no core state changes under noise. The controller never senses noise itself. Every window starts from the converter's timing pulse.

The window length is not a fixed constant. After reset the controller runs a built-in self-test, and the core stays stopped for all of it. During the test only a separate test checker, which runs a known workload, receives a clock enable. On each noise pulse the controller stops the checker for a candidate number of cycles and then samples the checker's error flag. Candidates rise from zero. One passing trial is not enough to accept a candidate, because an error can go unseen (fault masking) and the noise length can change from one event to the next. A candidate is accepted only after a run of consecutive clean trials. Any failure moves the sweep on to the next longer candidate and clears the run. The stored window is the accepted candidate plus a safety margin, limited to the largest value the counter can hold. If the sweep passes the top candidate with no success, the controller raises a fail flag and uses the largest window. In both cases it then enters normal mode and stays there until the next reset.

All pins are plain control and status levels or pulses. The block has no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `noise_gate_ctrl`

## Requirements
- R1: After reset: core_clk_en_o=0, chk_clk_en_o=1, test_done_o=0, test_fail_o=0, win_len_o=0.
- R2: While test_done_o is 0, core_clk_en_o stays 0.
- R3: During the test, a noise pulse sampled at an edge while the checker is idle (not gated, not being sampled) makes chk_clk_en_o low for exactly the current candidate number of cycles, starting the next cycle. The first candidate after reset is 0. The error flag is sampled at the edge that ends the first cycle after the gated stretch. Noise pulses that arrive while the checker is gated or being sampled are ignored.
- R4: A trial whose sampled chk_err_i is 1 increments the candidate by one and clears the consecutive-pass count.
- R5: When TRIALS (default 8) consecutive trials of one candidate pass, test_done_o rises and win_len_o becomes min(candidate+MARGIN, 2^WIN_W-1), with MARGIN=2 and WIN_W=8 by default.
- R6: If the candidate 2^WIN_W-1 fails a trial, test_fail_o and test_done_o rise and win_len_o becomes 2^WIN_W-1.
- R7: Once test_done_o is 1, it, test_fail_o and win_len_o hold their values until reset.
- R8: In normal mode, a noise pulse sampled at an edge makes core_clk_en_o 0 for exactly win_len_o cycles, starting the next cycle.
- R9: A noise pulse that arrives while a normal-mode window is open restarts the window. The enable then stays low for win_len_o cycles after the latest pulse.
- R10: In normal mode, core_clk_en_o is 1 whenever no window is open, and chk_clk_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_pulse_i | input | 1 | Switching-event timing pulse from the converter controller |
| chk_err_i | input | 1 | Error flag of the test checker |
| core_clk_en_o | output | 1 | Registered clock enable for the processor core |
| chk_clk_en_o | output | 1 | Registered clock enable for the test checker |
| test_done_o | output | 1 | Self-test finished, normal mode active |
| test_fail_o | output | 1 | No candidate passed up to the largest window |
| win_len_o | output | WIN_W | Stored gating window length in cycles |

## Verification
The hardest states to reach from the pins are the top of the sweep. These are an acceptance at a candidate close enough to the limit that the margin saturates, and a failure of the last candidate. Both need hundreds of consecutive trials, so directed runs hold the error flag high for every candidate below a chosen point, or for all of them. A seeded random run models varying noise length and masked errors. It predicts the accepted candidate only from the gate lengths it observes and the flags it drives. Retriggered windows are placed at chosen offsets inside an open window.

// File: rtl/ngc_pkg.sv
package ngc_pkg;
  typedef enum logic [1:0] {
    BS_WAIT   = 2'd0,
    BS_GATE   = 2'd1,
    BS_SAMPLE = 2'd2,
    BS_NORMAL = 2'd3
  } bist_st_e;
endpackage

// File: rtl/ngc_win_sat.sv
module ngc_win_sat #(
  parameter int WIN_W  = 8,
  parameter int MARGIN = 2
) (
  input  logic [WIN_W-1:0] cand_i,
  output logic [WIN_W-1:0] win_o
);
  localparam logic [WIN_W:0] MARGIN_W = (WIN_W+1)'(MARGIN);
  localparam logic [WIN_W:0] LIMIT    = {1'b0, {WIN_W{1'b1}}};

  logic [WIN_W:0] sum;

  always_comb begin
    sum = {1'b0, cand_i} + MARGIN_W;
    if (sum > LIMIT) win_o = LIMIT[WIN_W-1:0];
    else             win_o = sum[WIN_W-1:0];
  end
endmodule

// File: rtl/ngc_bist.sv
module ngc_bist
  import ngc_pkg::*;
#(
  parameter int WIN_W  = 8,
  parameter int TRIALS = 8,
  parameter int MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             err_i,
  output logic             chk_en_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [WIN_W-1:0] win_o
);
  localparam int PW = $clog2(TRIALS + 1);
  localparam logic [WIN_W-1:0] MAXW = {WIN_W{1'b1}};
  localparam logic [PW-1:0] LAST_PASS = PW'(TRIALS - 1);

  bist_st_e st_q, st_n;
  logic [WIN_W-1:0] cand_q, cand_n;
  logic [WIN_W-1:0] cnt_q, cnt_n;
  logic [PW-1:0]    pass_q, pass_n;
  logic             done_q, done_n, fail_q, fail_n, chk_q;
  logic [WIN_W-1:0] win_q, win_n, win_acc;

  ngc_win_sat #(.WIN_W(WIN_W), .MARGIN(MARGIN)) u_sat (
    .cand_i(cand_q),
    .win_o (win_acc)
  );

  always_comb begin
    st_n   = st_q;
    cand_n = cand_q;
    cnt_n  = cnt_q;
    pass_n = pass_q;
    done_n = done_q;
    fail_n = fail_q;
    win_n  = win_q;
    unique case (st_q)
      BS_WAIT: begin
        if (pulse_i) begin
          if (cand_q == '0) begin
            st_n = BS_SAMPLE;
          end else begin
            cnt_n = cand_q;
            st_n  = BS_GATE;
          end
        end
      end
      BS_GATE: begin
        if (cnt_q == WIN_W'(1)) st_n = BS_SAMPLE;
        cnt_n = cnt_q - 1'b1;
      end
      BS_SAMPLE: begin
        if (!err_i) begin
          if (pass_q == LAST_PASS) begin
            win_n  = win_acc;
            done_n = 1'b1;
            st_n   = BS_NORMAL;
          end else begin
            pass_n = pass_q + 1'b1;
            st_n   = BS_WAIT;
          end
        end else begin
          pass_n = '0;
          if (cand_q == MAXW) begin
            fail_n = 1'b1;
            done_n = 1'b1;
            win_n  = MAXW;
            st_n   = BS_NORMAL;
          end else begin
            cand_n = cand_q + 1'b1;
            st_n   = BS_WAIT;
          end
        end
      end
      default: st_n = BS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BS_WAIT;
      cand_q <= '0;
      cnt_q  <= '0;
      pass_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      win_q  <= '0;
      chk_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
      pass_q <= pass_n;
      done_q <= done_n;
      fail_q <= fail_n;
      win_q  <= win_n;
      chk_q  <= (st_n != BS_GATE);
    end
  end

  assign chk_en_o = chk_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign win_o    = win_q;
endmodule

// File: rtl/ngc_gate.sv
module ngc_gate #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             pulse_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             en_o
);
  logic [WIN_W-1:0] rem_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      en_q  <= 1'b0;
    end else if (!enable_i) begin
      rem_q <= '0;
      en_q  <= 1'b0;
    end else if (pulse_i) begin
      rem_q <= win_i;
      en_q  <= (win_i == '0);
    end else if (rem_q > WIN_W'(1)) begin
      rem_q <= rem_q - 1'b1;
    end else begin
      rem_q <= '0;
      en_q  <= 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl #(
  parameter int WIN_W  = 8,
  parameter int TRIALS = 8,
  parameter int MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             noise_pulse_i,
  input  logic             chk_err_i,
  output logic             core_clk_en_o,
  output logic             chk_clk_en_o,
  output logic             test_done_o,
  output logic             test_fail_o,
  output logic [WIN_W-1:0] win_len_o
);
  logic             done_w;
  logic [WIN_W-1:0] win_w;

  ngc_bist #(.WIN_W(WIN_W), .TRIALS(TRIALS), .MARGIN(MARGIN)) u_bist (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (noise_pulse_i),
    .err_i   (chk_err_i),
    .chk_en_o(chk_clk_en_o),
    .done_o  (done_w),
    .fail_o  (test_fail_o),
    .win_o   (win_w)
  );

  ngc_gate #(.WIN_W(WIN_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(done_w),
    .pulse_i (noise_pulse_i),
    .win_i   (win_w),
    .en_o    (core_clk_en_o)
  );

  assign test_done_o = done_w;
  assign win_len_o   = win_w;
endmodule

// File: rtl/ngc_checker.sv
module ngc_checker #(
  parameter int WIN_W  = 8,
  parameter int MARGIN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             noise_pulse_i,
  input logic             core_clk_en_o,
  input logic             chk_clk_en_o,
  input logic             test_done_o,
  input logic             test_fail_o,
  input logic [WIN_W-1:0] win_len_o
);
  localparam logic [WIN_W-1:0] MAXW = {WIN_W{1'b1}};
  localparam logic [WIN_W:0] MARGIN_W = (WIN_W+1)'(MARGIN);

  a_r2_core_off_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    !test_done_o |-> !core_clk_en_o);

  a_r7_result_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o |=> test_done_o && $stable(win_len_o) && $stable(test_fail_o));

  a_r10_checker_runs: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o |-> chk_clk_en_o);

  a_r8_pulse_closes: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o && noise_pulse_i |=> !core_clk_en_o);

  a_r6_fail_max: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail_o |-> test_done_o && (win_len_o == MAXW));

  a_r5_margin_floor: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o |-> ({1'b0, win_len_o} >= MARGIN_W));
endmodule

bind noise_gate_ctrl ngc_checker #(.WIN_W(WIN_W), .MARGIN(MARGIN)) u_ngc_checker (.*);

// File: tb/noise_gate_ctrl_bench.sv
module noise_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W  = 8;
  localparam int TRIALS = 8;
  localparam int MARGIN = 2;
  localparam int MAXW   = (1 << WIN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic noise = 1'b0;
  logic err = 1'b0;
  logic core_en, chk_en, done, fail;
  logic [WIN_W-1:0] win;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_gate_ctrl #(.WIN_W(WIN_W), .TRIALS(TRIALS), .MARGIN(MARGIN)) u_noise_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .noise_pulse_i(noise), .chk_err_i(err),
    .core_clk_en_o(core_en), .chk_clk_en_o(chk_en), .test_done_o(done),
    .test_fail_o(fail), .win_len_o(win)
  );

  function automatic int exp_win(input int cand);
    return (cand + MARGIN > MAXW) ? MAXW : cand + MARGIN;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    noise = 1'b0; err = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One self-test trial; mode 0 random noise model, 1 fail below limit, 2 always fail
  int exp_cand, exp_pass;
  int rnd_d;
  bit core_low_ok;

  task automatic trial(input int mode, input int limit);
    int g;
    bit e;
    g = 0;
    noise = 1'b1;
    @(posedge clk); #1 noise = 1'b0;
    forever begin
      @(negedge clk);
      if (core_en) core_low_ok = 1'b0;
      if (!chk_en) g++; else break;
    end
    check(g == exp_cand, "R3 gate length", g, exp_cand);
    case (mode)
      0: e = (g < rnd_d + int'($urandom % 2)) && ($urandom % 3 != 0);
      1: e = (g < limit);
      default: e = 1'b1;
    endcase
    err = e;
    @(posedge clk); #1 err = 1'b0;
    if (e) begin
      exp_pass = 0;
      if (exp_cand < MAXW) exp_cand++;
      else exp_cand = MAXW + 1;
    end else begin
      exp_pass++;
    end
    @(negedge clk);
  endtask

  task automatic run_test(input int mode, input int limit, input string tag);
    int guard;
    exp_cand = 0; exp_pass = 0; guard = 0; core_low_ok = 1'b1;
    do_reset();
    check(!core_en && chk_en && !done && !fail && win == 0, "R1 reset state",
          {core_en, chk_en, done, fail}, 4'b0100);
    while (!done && guard < 400) begin
      trial(mode, limit);
      guard++;
      if (!done && exp_cand <= MAXW) begin
        check(exp_pass < TRIALS, "R4 no early accept", exp_pass, TRIALS - 1);
      end
    end
    check(core_low_ok, "R2 core enable low during test", core_low_ok, 1);
    check(done, "R5 test done", done, 1);
    if (exp_cand > MAXW) begin
      check(fail && win == MAXW, "R6 fail at limit", win, MAXW);
    end else begin
      check(!fail && exp_pass == TRIALS, {tag, " R5 pass run"}, exp_pass, TRIALS);
      check(int'(win) == exp_win(exp_cand), {tag, " R5 window"}, win, exp_win(exp_cand));
    end
  endtask

  task automatic window(input int k, output int low);
    low = 0;
    noise = 1'b1;
    @(posedge clk); #1 noise = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (!core_en) low++;
    end
    if (k > 0) begin
      noise = 1'b1;
      @(posedge clk); #1 noise = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (core_en) break;
      low++;
      if (low > 2 * MAXW + 4) break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int low, w0, f0;
    void'($urandom(32'd20240611));

    // Random noise length with variation and masked errors
    rnd_d = 3 + int'($urandom % 10);
    run_test(0, 0, "random");
    w0 = int'(win); f0 = int'(fail);
    repeat (3) @(negedge clk);
    check(core_en && chk_en, "R10 enables high when idle", {core_en, chk_en}, 2'b11);

    for (int r = 0; r < 4; r++) begin
      window(0, low);
      check(low == w0, "R8 window length", low, w0);
      check(chk_en, "R10 checker enable in normal mode", chk_en, 1);
    end
    for (int r = 0; r < 4; r++) begin
      int k;
      k = 1 + int'($urandom % (w0 - 1));
      window(k, low);
      check(low == k + w0, "R9 retrigger restarts window", low, k + w0);
    end
    // Pulse on the last low cycle of a window
    window(w0 - 1, low);
    check(low == 2 * w0 - 1, "R9 retrigger at window end", low, 2 * w0 - 1);
    check(done && int'(win) == w0 && int'(fail) == f0, "R7 result sticky",
          win, w0);

    // Acceptance close to the limit: margin saturates
    run_test(1, MAXW - 1, "saturate");
    window(0, low);
    check(low == MAXW, "R8 saturated window length", low, MAXW);

    // Nothing ever passes
    run_test(2, 0, "fail");
    check(fail, "R6 fail flag", fail, 1);
    repeat (2) @(negedge clk);
    check(core_en && done, "R7 R10 normal after fail", {core_en, done}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule